// File: doc/BRIEF.md
# Reshapeable Block RAM

This block is a synchronous on-chip RAM with a fixed 16384-bit store. A static 4-bit shape code selects how the store is seen. It can be one port with a width from 16 bits down to 1 bit, or two independent ports with a width from 8 bits down to 1 bit. The address is always presented on 14-bit inputs. Each shape uses only as many low address bits as its depth needs.

The write data and read data travel on one 16-bit input bus and one 16-bit output bus. In two-port shapes these buses are split into two lanes of equal width. Port A uses the low lane and port B uses the lane just above it. Both ports share the clock and may read or write in the same cycle.

The store is laid out as one linear string of bits. A word written in one shape can therefore be read back in any other shape at a predictable position. The memory, the shape code and the enables are plain pins. There is no handshake, because every access completes in a fixed single cycle and the RAM never stalls.

Top module: `arm_bram`

## Requirements
- R1: The store is one linear array of 16384 bits. The word at truncated address A in width W occupies bits A*W to A*W+W-1, so data written in one shape reads back at that bit position in every other shape.
- R2: Shape code bit 3 selects two ports (1) or one port (0), and bits 2:0 give log2 of the width W. The supported one-port codes are 0000 to 0100 (W = 1, 2, 4, 8, 16). The supported two-port codes are 1000 to 1011 (W = 1, 2, 4, 8). Every other code behaves exactly like 0000.
- R3: Only the low 14-log2(W) address bits are used. Higher address bits have no effect.
- R4: In one-port shapes, writes take `din[W-1:0]`, reads appear on `dout[W-1:0]`, and only `addr_a` and `we_a` are used. `we_b` and `addr_b` do not change the store.
- R5: In two-port shapes, port A writes from `din[W-1:0]` and reads to `dout[W-1:0]`. Port B writes from `din[2W-1:W]` and reads to `dout[2W-1:W]`, using its own address and enable.
- R6: A read returns the stored word on `dout` one clock after the address is presented.
- R7: A port that writes shows its own newly written data on its lane of `dout` in the next cycle.
- R8: Bits of `dout` outside the active lanes are zero.
- R9: When both ports write the same word in the same cycle, the store keeps port B's data.
- R10: A port that reads a word while the other port writes that word in the same cycle returns the old contents.
- R11: While `rst_n` is low, `dout` is zero. Reset does not clear the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| mode_code | input | 4 | Static shape code; change it only while both enables are low |
| addr_a | input | 14 | Port A word address |
| addr_b | input | 14 | Port B word address (two-port shapes) |
| din | input | 16 | Shared write data, split into lanes by shape |
| we_a | input | 1 | Port A write enable |
| we_b | input | 1 | Port B write enable (two-port shapes) |
| dout | output | 16 | Registered read data, split into lanes by shape |

## Verification
The assertions check three things on every cycle. Each writing port echoes its own lane on the next cycle. Bits outside the active lanes of `dout` stay zero. Unsupported codes leave only bit 0 of `dout` live. The bench's scenarios are the only way to show the behaviours that depend on stored history: the linear bit layout across shape changes, address truncation, the resolution of a two-port collision, the old-data result of a cross-port read, and the fact that `we_b` has no effect in one-port shapes. A behavioural bit-array model in the bench predicts `dout` for every clock.

// File: rtl/arm_pkg.sv
package arm_pkg;
  // Decoded shape: two-port flag and log2 of the lane width.
  typedef struct packed {
    logic       dual;
    logic [2:0] wsel;
  } arm_shape_t;
endpackage

// File: rtl/arm_mode_decode.sv
module arm_mode_decode
  import arm_pkg::*;
#(
  parameter int LOG_W = 4
) (
  input  logic [3:0] mode_code,
  output arm_shape_t shape
);
  logic       dual_req;
  logic [2:0] ws_req;
  logic       legal;

  always_comb begin
    dual_req = mode_code[3];
    ws_req   = mode_code[2:0];
    // Two-port shapes stop one width step below the full row width.
    if (dual_req) legal = (ws_req < 3'(LOG_W));
    else          legal = (ws_req <= 3'(LOG_W));
    if (legal) begin
      shape.dual = dual_req;
      shape.wsel = ws_req;
    end else begin
      shape.dual = 1'b0;
      shape.wsel = 3'd0;
    end
  end
endmodule

// File: rtl/arm_port_map.sv
module arm_port_map
  import arm_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 16,
  parameter int PORT_IDX = 0,
  localparam int OFF_W   = $clog2(DATA_W),
  localparam int ROW_AW  = ADDR_W - OFF_W
) (
  input  arm_shape_t          shape,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   din,
  output logic [ROW_AW-1:0]   row,
  output logic [OFF_W-1:0]    off,
  output logic [DATA_W-1:0]   lane_mask,
  output logic [DATA_W-1:0]   lane_data,
  output logic [DATA_W-1:0]   wr_mask,
  output logic [DATA_W-1:0]   wr_data
);
  logic [ADDR_W-1:0] depth_m;
  logic [ADDR_W-1:0] a_tr;
  logic [ADDR_W-1:0] bitpos;
  logic [OFF_W:0]    wbits;
  logic [DATA_W-1:0] src;

  // Port B draws its lane from just above port A's lane.
  generate
    if (PORT_IDX == 0) begin : g_low_lane
      assign src = din;
    end else begin : g_high_lane
      assign src = din >> wbits;
    end
  endgenerate

  always_comb begin
    wbits     = (OFF_W + 1)'(1) << shape.wsel;
    depth_m   = {ADDR_W{1'b1}} >> shape.wsel;
    a_tr      = addr & depth_m;
    bitpos    = a_tr << shape.wsel;
    row       = bitpos[ADDR_W-1:OFF_W];
    off       = bitpos[OFF_W-1:0];
    lane_mask = ~({DATA_W{1'b1}} << wbits);
    lane_data = src & lane_mask;
    wr_mask   = lane_mask << off;
    wr_data   = lane_data << off;
  end
endmodule

// File: rtl/arm_store.sv
module arm_store #(
  parameter int ROW_W  = 16,
  parameter int ROW_AW = 10,
  localparam int ROWS  = 1 << ROW_AW
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ROW_AW-1:0] a_row,
  input  logic [ROW_W-1:0]  a_mask,
  input  logic [ROW_W-1:0]  a_data,
  input  logic              b_we,
  input  logic [ROW_AW-1:0] b_row,
  input  logic [ROW_W-1:0]  b_mask,
  input  logic [ROW_W-1:0]  b_data,
  output logic [ROW_W-1:0]  a_rd,
  output logic [ROW_W-1:0]  b_rd
);
  logic [ROW_W-1:0] mem [ROWS];
  logic             same_row;

  assign a_rd     = mem[a_row];
  assign b_rd     = mem[b_row];
  assign same_row = a_we & b_we & (a_row == b_row);

  always_ff @(posedge clk) begin
    if (same_row) begin
      // One merged update; port B's bits override port A's where lanes overlap.
      mem[b_row] <= (mem[b_row] & ~(a_mask | b_mask)) | (a_data & ~b_mask) | b_data;
    end else begin
      if (a_we) mem[a_row] <= (mem[a_row] & ~a_mask) | a_data;
      if (b_we) mem[b_row] <= (mem[b_row] & ~b_mask) | b_data;
    end
  end
endmodule

// File: rtl/arm_bram.sv
module arm_bram
  import arm_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        mode_code,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din,
  input  logic              we_a,
  input  logic              we_b,
  output logic [DATA_W-1:0] dout
);
  localparam int OFF_W  = $clog2(DATA_W);
  localparam int ROW_AW = ADDR_W - OFF_W;
  localparam int NPORT  = 2;

  arm_shape_t shape;

  logic [ADDR_W-1:0] addr_v    [NPORT];
  logic              we_v      [NPORT];
  logic [ROW_AW-1:0] row_v     [NPORT];
  logic [OFF_W-1:0]  off_v     [NPORT];
  logic [DATA_W-1:0] lmask_v   [NPORT];
  logic [DATA_W-1:0] ldata_v   [NPORT];
  logic [DATA_W-1:0] wmask_v   [NPORT];
  logic [DATA_W-1:0] wdata_v   [NPORT];
  logic [DATA_W-1:0] rword_v   [NPORT];
  logic [DATA_W-1:0] pick_v    [NPORT];
  logic [OFF_W:0]    wbits;
  logic [DATA_W-1:0] dout_d;
  logic [DATA_W-1:0] dout_q;

  arm_mode_decode #(.LOG_W(OFF_W)) u_dec (
    .mode_code (mode_code),
    .shape     (shape)
  );

  assign addr_v[0] = addr_a;
  assign addr_v[1] = addr_b;
  assign we_v[0]   = we_a;
  assign we_v[1]   = we_b & shape.dual;

  generate
    for (genvar g = 0; g < NPORT; g++) begin : g_port
      arm_port_map #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .PORT_IDX (g)
      ) u_map (
        .shape     (shape),
        .addr      (addr_v[g]),
        .din       (din),
        .row       (row_v[g]),
        .off       (off_v[g]),
        .lane_mask (lmask_v[g]),
        .lane_data (ldata_v[g]),
        .wr_mask   (wmask_v[g]),
        .wr_data   (wdata_v[g])
      );
    end
  endgenerate

  arm_store #(.ROW_W(DATA_W), .ROW_AW(ROW_AW)) u_store (
    .clk    (clk),
    .a_we   (we_v[0]),
    .a_row  (row_v[0]),
    .a_mask (wmask_v[0]),
    .a_data (wdata_v[0]),
    .b_we   (we_v[1]),
    .b_row  (row_v[1]),
    .b_mask (wmask_v[1]),
    .b_data (wdata_v[1]),
    .a_rd   (rword_v[0]),
    .b_rd   (rword_v[1])
  );

  // Own write echoes (write-first); otherwise the pre-edge contents are returned.
  always_comb begin
    wbits = (OFF_W + 1)'(1) << shape.wsel;
    for (int i = 0; i < NPORT; i++) begin
      if (we_v[i]) pick_v[i] = ldata_v[i];
      else         pick_v[i] = (rword_v[i] >> off_v[i]) & lmask_v[i];
    end
    dout_d = pick_v[0];
    if (shape.dual) dout_d = dout_d | (pick_v[1] << wbits);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dout_q <= '0;
    else        dout_q <= dout_d;
  end

  assign dout = dout_q;
endmodule

// File: rtl/arm_bram_chk.sv
module arm_bram_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        mode_code,
  input logic [ADDR_W-1:0] addr_a,
  input logic [ADDR_W-1:0] addr_b,
  input logic [DATA_W-1:0] din,
  input logic              we_a,
  input logic              we_b,
  input logic [DATA_W-1:0] dout
);
  localparam int LOG_W = $clog2(DATA_W);

  logic              ok_c;
  logic              dual_c;
  logic [2:0]        ws_c;
  logic [LOG_W:0]    w_c;
  logic [DATA_W-1:0] lm_c;
  logic [DATA_W-1:0] used_c;

  always_comb begin
    ok_c   = mode_code[3] ? (mode_code[2:0] < 3'(LOG_W)) : (mode_code[2:0] <= 3'(LOG_W));
    dual_c = ok_c & mode_code[3];
    ws_c   = ok_c ? mode_code[2:0] : 3'd0;
    w_c    = (LOG_W + 1)'(1) << ws_c;
    lm_c   = ~({DATA_W{1'b1}} << w_c);
    used_c = dual_c ? (lm_c | (lm_c << w_c)) : lm_c;
  end

  // R7: port A's lane echoes the data it wrote.
  p_echo_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_a && $stable(mode_code)) |=> ((dout & $past(lm_c)) == ($past(din) & $past(lm_c))));

  // R7, R5: port B's lane echoes its own write in two-port shapes.
  p_echo_b_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_b && dual_c && $stable(mode_code)) |=>
      (((dout >> $past(w_c)) & $past(lm_c)) == (($past(din) >> $past(w_c)) & $past(lm_c))));

  // R8: inactive output bits stay at zero.
  p_idle_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode_code) |=> ((dout & ~$past(used_c)) == '0));

  // R2: unsupported codes leave only bit 0 live.
  p_fallback_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok_c && $stable(mode_code)) |=> (dout[DATA_W-1:1] == '0));
endmodule

bind arm_bram arm_bram_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_arm_bram.sv
`timescale 1ns/1ps
module test_arm_bram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode_code = 4'b0100;
  logic [13:0] addr_a = '0;
  logic [13:0] addr_b = '0;
  logic [15:0] din = '0;
  logic        we_a = 1'b0;
  logic        we_b = 1'b0;
  logic [15:0] dout;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] mref [1024];

  always #2 clk = ~clk;

  arm_bram i_arm_bram (
    .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .addr_a(addr_a),
    .addr_b(addr_b), .din(din), .we_a(we_a), .we_b(we_b), .dout(dout)
  );

  function automatic logic getb(int i);
    return mref[i >> 4][i & 15];
  endfunction

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: dout=%h expected %h", tag, got, exp);
    end
  endtask

  // One clock of traffic; the model predicts dout for the following cycle.
  task automatic step(input logic [3:0] m, input logic [13:0] a1, input logic [13:0] a2,
                      input logic [15:0] d, input logic w1, input logic w2, input string tag);
    logic dual;
    int ws, w, b1, b2;
    logic [15:0] o1, o2, exp;
    dual = m[3];
    ws = int'(m[2:0]);
    if ((dual && ws > 3) || (!dual && ws > 4)) begin dual = 0; ws = 0; end
    w  = 1 << ws;
    b1 = (int'(a1) & ((1 << (14 - ws)) - 1)) * w;
    b2 = (int'(a2) & ((1 << (14 - ws)) - 1)) * w;
    o1 = '0; o2 = '0;
    for (int k = 0; k < w; k++) begin
      o1[k] = getb(b1 + k);
      o2[k] = getb(b2 + k);
    end
    if (w1) for (int k = 0; k < w; k++) o1[k] = d[k];
    if (dual && w2) for (int k = 0; k < w; k++) o2[k] = d[w + k];
    exp = dual ? (o1 | (o2 << w)) : o1;
    if (w1) for (int k = 0; k < w; k++) mref[(b1 + k) >> 4][(b1 + k) & 15] = d[k];
    if (dual && w2) for (int k = 0; k < w; k++) mref[(b2 + k) >> 4][(b2 + k) & 15] = d[w + k];
    mode_code = m; addr_a = a1; addr_b = a2; din = d; we_a = w1; we_b = w2;
    @(posedge clk);
    #1;
    check(tag, dout, exp);
  endtask

  initial begin
    #(200000 * 4);
    n_run++; n_fail++;
    $display("FAIL watchdog: dout=%h expected completion", dout);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R11 reset", dout, 16'h0000);
    rst_n = 1'b1;

    // R7: fill the whole store as 1024x16 one-port words.
    for (int i = 0; i < 1024; i++) step(4'b0100, 14'(i), 14'h0, 16'(i * 40503 + 7), 1, 0, "R7 fill");
    // R6: read-back latency.
    for (int i = 0; i < 8; i++) step(4'b0100, 14'(i * 129), 14'h0, 16'hFFFF, 0, 0, "R6 read");
    // R3: upper address bits ignored.
    step(4'b0100, 14'h3C05, 14'h0, 16'h0, 0, 0, "R3 x16 trunc");
    step(4'b0011, 14'h3805, 14'h0, 16'h005A, 1, 0, "R3 x8 write");
    step(4'b0011, 14'h0005, 14'h0, 16'h0, 0, 0, "R3 x8 read");
    // R1: layout seen through other widths.
    step(4'b0100, 14'd2, 14'h0, 16'hA5C3, 1, 0, "R1 write word");
    for (int i = 32; i < 48; i++) step(4'b0000, 14'(i), 14'h0, 16'h0, 0, 0, "R1 x1 view");
    for (int i = 8; i < 12; i++) step(4'b0010, 14'(i), 14'h0, 16'h0, 0, 0, "R1 x4 view");
    step(4'b0001, 14'd21, 14'h0, 16'h0, 0, 0, "R1 x2 view");
    // R4: port B ignored in one-port shapes.
    step(4'b0011, 14'd40, 14'd41, 16'h3C77, 1, 1, "R4 single we_b");
    step(4'b0011, 14'd41, 14'h0, 16'h0, 0, 0, "R4 addr_b untouched");
    step(4'b0001, 14'd100, 14'd101, 16'hFFFF, 0, 1, "R4 we_b alone");
    step(4'b0001, 14'd101, 14'h0, 16'h0, 0, 0, "R4 read back");
    // R5: two-port lanes for each two-port width.
    for (int m = 8; m < 12; m++) begin
      step(4'(m), 14'(300 + m), 14'(700 + m), 16'hB6E1 ^ 16'(m), 1, 1, "R5 dual write");
      step(4'(m), 14'(700 + m), 14'(300 + m), 16'h0, 0, 0, "R5 dual read swap");
      step(4'(m), 14'(300 + m), 14'(9000 + m), 16'h0, 0, 0, "R8 idle bits");
    end
    // R9: same-word collision.
    step(4'b1010, 14'd77, 14'd77, 16'h00C3, 1, 1, "R9 collide");
    step(4'b1010, 14'd77, 14'd77, 16'h0, 0, 0, "R9 survivor");
    // R10: cross-port read during write.
    step(4'b1001, 14'd55, 14'd55, 16'h000C, 0, 1, "R10 B writes A reads");
    step(4'b1001, 14'd55, 14'd55, 16'h0003, 1, 0, "R10 A writes B reads");
    step(4'b1001, 14'd55, 14'd55, 16'h0, 0, 0, "R10 settle");
    // R2: unsupported codes act as 16384x1 one-port.
    step(4'b0111, 14'd5000, 14'd5001, 16'hFFFF, 1, 1, "R2 code 0111");
    step(4'b1100, 14'd5001, 14'd5000, 16'h0, 0, 1, "R2 code 1100");
    step(4'b1111, 14'd5000, 14'h0, 16'h0, 0, 0, "R2 code 1111");
    step(4'b0000, 14'd5001, 14'h0, 16'h0, 0, 0, "R2 compare x1");
    // R11: reset clears output but not the store.
    rst_n = 1'b0;
    #1;
    check("R11 async clear", dout, 16'h0000);
    @(posedge clk);
    #1;
    rst_n = 1'b1;
    step(4'b0100, 14'd2, 14'h0, 16'h0, 0, 0, "R11 store kept");

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule